// File: doc/BRIEF.md
# Boundary-scan data register path

This block holds the two test data registers that a test access port places between its serial input and serial output during a data scan: a one-stage bypass register and a chain of boundary cells, one per device pin. Each boundary cell has a capture/shift stage and an update latch. The block receives the already-decoded instruction and one strobe per controller phase: test-logic-reset, capture, shift and update. For each of these it loads, moves or applies data according to the active instruction. It also sits in the pin path. It passes the functional core values to the output pins, or substitutes the update latches, or forces every output enable off.

The instruction code selects one of five modes. These act as the states of the block, and the output process is a unique case over them. The modes are EXTEST (code 0), SAMPLE (code 1, sample and preload), BYPASS (code 2 and the unused codes 5, 6 and 7), HIGHZ (code 3) and CLAMP (code 4). There is one transition between modes: any change of the instruction input moves the block to the decoded mode in the same cycle. In EXTEST and SAMPLE the boundary chain is the selected register. In the other three modes the bypass stage is selected.

All actions happen on the rising edge of `clk` in the cycle whose strobe is high. The tester is expected to raise at most one strobe per cycle. When several are raised together, the order of precedence is reset, then capture, then shift, then update. A parameter mask tags each cell as an input-pin cell (0) or an output-pin cell (1).

Top module: `bsr_dr_path`

## Requirements
- R1: While `rst_n` is low, and on any edge with `tlr_i` high, every boundary stage, every update latch and the bypass stage become 0. After this, `tdo_o` reads 0.
- R2: The mode decodes from `instr_i` as follows: 0 is EXTEST, 1 is SAMPLE, 2 is BYPASS, 3 is HIGHZ, 4 is CLAMP, and 5, 6 and 7 are BYPASS. The boundary chain is the selected register only in EXTEST and SAMPLE; in every other mode the bypass stage is selected.
- R3: On an edge with `capture_i` high while the boundary chain is selected, cell i loads `pin_in_i[i]` if it is an input cell and `core_out_i[i]` if it is an output cell.
- R4: In EXTEST, each output-role bit of `pin_out_o` equals that cell's update latch. The value changes only on the edge where an update loads the latch.
- R5: In SAMPLE, an edge with `update_i` high copies every boundary stage into its update latch. Throughout SAMPLE, `pin_out_o` equals `core_out_i` on the output-role bits and `oe_off_o` is 0.
- R6: In BYPASS, a capture edge loads 0 into the bypass stage and a shift edge loads `tdi_i` into it. `tdo_o` is the bypass stage, and `pin_out_o` follows `core_out_i` on the output-role bits.
- R7: On a shift edge, only the selected register moves. In the boundary chain, cell i takes the value of cell i+1, the last cell takes `tdi_i`, and `tdo_o` reads cell 0. The unselected register keeps its value.
- R8: On an edge with no strobe high, all stages and latches keep their values. This covers the select, exit, pause and idle phases.
- R9: In HIGHZ, `oe_off_o` is 1, the bypass stage is selected, and `pin_out_o` follows `core_out_i`.
- R10: In CLAMP, the output-role bits of `pin_out_o` come from the update latches, `oe_off_o` is 0 and the bypass stage is selected. An update edge leaves the latches unchanged.
- R11: The bits of `pin_out_o` that belong to input-role cells are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock, rising edge active |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| tlr_i | input | 1 | Controller is in test-logic-reset |
| capture_i | input | 1 | Data-register capture phase |
| shift_i | input | 1 | Data-register shift phase |
| update_i | input | 1 | Data-register update phase |
| instr_i | input | 3 | Decoded instruction code |
| tdi_i | input | 1 | Serial test data in |
| pin_in_i | input | CELLS | Values present at the pins, one per cell |
| core_out_i | input | CELLS | Functional values the core wants on the pins |
| pin_out_o | output | CELLS | Values to drive on the output pins |
| oe_off_o | output | 1 | Forces all output enables off |
| tdo_o | output | 1 | Serial output of the selected register |

## Verification
Two functions can coincide in one cycle. The first case is an update strobe that arrives in the same cycle as an instruction change, for example from SAMPLE into EXTEST or CLAMP. The second is a capture edge while `pin_in_i` and `core_out_i` are toggling. The bench provokes both with a long random run. That run changes the instruction on about one cycle in eight, independently of the strobe choice, and draws new pin values every cycle. A behavioural model is compared against `pin_out_o`, `oe_off_o` and `tdo_o` every cycle. The model judges each combined cycle this way: the update follows the mode in force at that edge, and the pin mux follows the new mode at once.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

    localparam int CODE_W = 3;

    typedef enum logic [2:0] {
        M_EXTEST = 3'd0,
        M_SAMPLE = 3'd1,
        M_BYPASS = 3'd2,
        M_HIGHZ  = 3'd3,
        M_CLAMP  = 3'd4
    } mode_e;

endpackage

// File: rtl/bsr_mode_dec.sv
module bsr_mode_dec
    import bsr_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    output mode_e             mode_o,
    output logic              bs_sel_o
);

    always_comb begin
        unique case (code_i)
            3'd0:    mode_o = M_EXTEST;
            3'd1:    mode_o = M_SAMPLE;
            3'd3:    mode_o = M_HIGHZ;
            3'd4:    mode_o = M_CLAMP;
            default: mode_o = M_BYPASS;
        endcase
    end

    always_comb begin
        unique case (mode_o)
            M_EXTEST, M_SAMPLE: bs_sel_o = 1'b1;
            default:            bs_sel_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/bsr_cell.sv
module bsr_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic cap_i,
    input  logic sh_i,
    input  logic upd_i,
    input  logic par_i,
    input  logic ser_i,
    output logic stage_o,
    output logic latch_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     stage_o <= 1'b0;
        else if (clr_i) stage_o <= 1'b0;
        else if (cap_i) stage_o <= par_i;
        else if (sh_i)  stage_o <= ser_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         latch_o <= 1'b0;
        else if (clr_i)                     latch_o <= 1'b0;
        else if (upd_i && !cap_i && !sh_i)  latch_o <= stage_o;
    end

    // R5: an update edge moves the stage into the latch
    p_cell_update_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && !cap_i && !sh_i && !clr_i) |=> (latch_o == $past(stage_o)));

endmodule

// File: rtl/bsr_bypass_stage.sv
module bsr_bypass_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic cap_i,
    input  logic sh_i,
    input  logic ser_i,
    output logic q_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q_o <= 1'b0;
        else if (clr_i) q_o <= 1'b0;
        else if (cap_i) q_o <= 1'b0;
        else if (sh_i)  q_o <= ser_i;
    end

    // R6: the bypass stage captures zero
    p_byp_cap_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cap_i |=> (q_o == 1'b0));

    // R6: a shift loads the serial input
    p_byp_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_i && !cap_i && !clr_i) |=> (q_o == $past(ser_i)));

endmodule

// File: rtl/bsr_dr_path.sv
module bsr_dr_path
    import bsr_pkg::*;
#(
    parameter int               CELLS     = 8,
    parameter logic [CELLS-1:0] CELL_ROLE = 8'hF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tlr_i,
    input  logic              capture_i,
    input  logic              shift_i,
    input  logic              update_i,
    input  logic [CODE_W-1:0] instr_i,
    input  logic              tdi_i,
    input  logic [CELLS-1:0]  pin_in_i,
    input  logic [CELLS-1:0]  core_out_i,
    output logic [CELLS-1:0]  pin_out_o,
    output logic              oe_off_o,
    output logic              tdo_o
);

    localparam int LAST = CELLS - 1;

    mode_e            mode;
    logic             bs_sel;
    logic             drive_latch;
    logic             bs_cap, bs_sh, bs_upd;
    logic             by_cap, by_sh;
    logic             byp_q;
    logic [CELLS-1:0] par_vec;
    logic [CELLS-1:0] ser_vec;
    logic [CELLS-1:0] stage_vec;
    logic [CELLS-1:0] latch_vec;

    bsr_mode_dec u_dec (
        .code_i  (instr_i),
        .mode_o  (mode),
        .bs_sel_o(bs_sel)
    );

    assign bs_cap = capture_i & bs_sel;
    assign bs_sh  = shift_i   & bs_sel;
    assign bs_upd = update_i  & bs_sel;
    assign by_cap = capture_i & ~bs_sel;
    assign by_sh  = shift_i   & ~bs_sel;

    assign par_vec = (CELL_ROLE & core_out_i) | (~CELL_ROLE & pin_in_i);
    assign ser_vec = {tdi_i, stage_vec[LAST:1]};

    for (genvar i = 0; i < CELLS; i++) begin : g_cell
        bsr_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr_i  (tlr_i),
            .cap_i  (bs_cap),
            .sh_i   (bs_sh),
            .upd_i  (bs_upd),
            .par_i  (par_vec[i]),
            .ser_i  (ser_vec[i]),
            .stage_o(stage_vec[i]),
            .latch_o(latch_vec[i])
        );
    end

    bsr_bypass_stage u_byp (
        .clk  (clk),
        .rst_n(rst_n),
        .clr_i(tlr_i),
        .cap_i(by_cap),
        .sh_i (by_sh),
        .ser_i(tdi_i),
        .q_o  (byp_q)
    );

    always_comb begin
        drive_latch = 1'b0;
        oe_off_o    = 1'b0;
        unique case (mode)
            M_EXTEST: drive_latch = 1'b1;
            M_CLAMP:  drive_latch = 1'b1;
            M_HIGHZ:  oe_off_o    = 1'b1;
            M_SAMPLE, M_BYPASS: ;
            default: ;
        endcase
    end

    assign pin_out_o = CELL_ROLE & (drive_latch ? latch_vec : core_out_i);
    assign tdo_o     = bs_sel ? stage_vec[0] : byp_q;

    // R8: the tester raises one strobe at a time
    p_strobes_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tlr_i, capture_i, shift_i, update_i}));

    // R1: test-logic-reset clears every register
    p_tlr_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tlr_i |=> (stage_vec == '0 && latch_vec == '0 && byp_q == 1'b0));

    // R8: no strobe, nothing moves
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(tlr_i || capture_i || shift_i || update_i)
        |=> ($stable(stage_vec) && $stable(latch_vec) && $stable(byp_q)));

    // R3: capture of the pin or core values into the chain
    p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (capture_i && bs_sel && !tlr_i) |=> (stage_vec == $past(par_vec)));

    // R7: chain shift enters at the far end, bypass untouched
    p_shift_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_i && bs_sel && !tlr_i && !capture_i)
        |=> (stage_vec[LAST] == $past(tdi_i) && $stable(byp_q)));

    // R10: latches change only on a boundary update or reset
    p_latch_guard_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(update_i && bs_sel) && !tlr_i |=> $stable(latch_vec));

endmodule

// File: tb/bsr_dr_path_bench.sv
module bsr_dr_path_bench;

    localparam int          N    = 8;
    localparam logic [N-1:0] ROLE = 8'hF0;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tlr = 1'b0, cap = 1'b0, sh = 1'b0, upd = 1'b0;
    logic [2:0]   instr = 3'd2;
    logic         tdi = 1'b0;
    logic [N-1:0] pin_in = '0, core_out = '0;
    logic [N-1:0] pin_out;
    logic         oe_off, tdo;

    int checks = 0;
    int errors = 0;

    // behavioural model state
    logic [N-1:0] m_sh = '0, m_up = '0;
    logic         m_byp = 1'b0;
    string        last_tag = "R1";

    always #4 clk = ~clk;

    bsr_dr_path #(.CELLS(N), .CELL_ROLE(ROLE)) u_bsr_dr_path (
        .clk(clk), .rst_n(rst_n), .tlr_i(tlr), .capture_i(cap),
        .shift_i(sh), .update_i(upd), .instr_i(instr), .tdi_i(tdi),
        .pin_in_i(pin_in), .core_out_i(core_out), .pin_out_o(pin_out),
        .oe_off_o(oe_off), .tdo_o(tdo)
    );

    function automatic int mode_of(logic [2:0] c);
        return (c <= 3'd4) ? int'(c) : 2;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        int m = mode_of(instr);
        bit sel = (m == 0 || m == 1);
        logic [N-1:0] exp_pins;
        string ptag, ttag;
        exp_pins = ROLE & ((m == 0 || m == 4) ? m_up : core_out);
        case (m)
            0: ptag = "R4";
            1: ptag = "R5";
            3: ptag = "R9";
            4: ptag = "R10";
            default: ptag = (instr > 3'd4) ? "R2" : "R6";
        endcase
        ttag = sel ? last_tag : ((instr > 3'd4) ? "R2" : "R6");
        check(ptag, 32'(pin_out & ROLE), 32'(exp_pins & ROLE));
        check("R11", 32'(pin_out & ~ROLE), 32'd0);
        check((m == 3) ? "R9" : ptag, 32'(oe_off), 32'(m == 3));
        check(ttag, 32'(tdo), 32'(sel ? m_sh[0] : m_byp));
    endtask

    task automatic model_edge();
        int m = mode_of(instr);
        bit sel = (m == 0 || m == 1);
        if (tlr) begin
            m_sh = '0; m_up = '0; m_byp = 1'b0; last_tag = "R1";
        end else if (cap) begin
            if (sel) begin
                for (int i = 0; i < N; i++)
                    m_sh[i] = ROLE[i] ? core_out[i] : pin_in[i];
            end else m_byp = 1'b0;
            last_tag = "R3";
        end else if (sh) begin
            if (sel) begin
                for (int i = 0; i < N - 1; i++) m_sh[i] = m_sh[i+1];
                m_sh[N-1] = tdi;
            end else m_byp = tdi;
            last_tag = "R7";
        end else if (upd) begin
            if (sel) m_up = m_sh;
            last_tag = (m == 4) ? "R10" : "R5";
        end else begin
            last_tag = "R8";
        end
    endtask

    // one cycle: drive at the falling edge, compare, then let the edge act
    task automatic cyc(int strobe, logic [2:0] code, logic d,
                       logic [N-1:0] pins, logic [N-1:0] core);
        @(negedge clk);
        tlr = (strobe == 1); cap = (strobe == 2);
        sh  = (strobe == 3); upd = (strobe == 4);
        instr = code; tdi = d; pin_in = pins; core_out = core;
        #1 compare_all();
        @(posedge clk);
        #1 model_edge();
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [2:0] code;
        repeat (3) @(negedge clk);
        // R1: reset state seen at the ports
        #1 check("R1", 32'(tdo), 32'd0);
        check("R1", 32'(pin_out), 32'd0);
        @(negedge clk) rst_n = 1'b1;

        // directed EXTEST: capture, scan a pattern in, apply it (R3, R4, R7)
        cyc(2, 3'd0, 1'b0, 8'h5A, 8'hC3);
        for (int i = 0; i < N; i++) cyc(3, 3'd0, 1'(8'hA6 >> i), 8'h00, 8'h00);
        cyc(0, 3'd0, 1'b0, 8'h00, 8'hFF);
        cyc(4, 3'd0, 1'b0, 8'h00, 8'hFF);
        cyc(0, 3'd0, 1'b0, 8'h00, 8'h0F);
        // R4: latches hold A6, output bits show A0
        @(negedge clk) #1 check("R4", 32'(pin_out), 32'hA0);

        // CLAMP keeps latches through an update (R10); HIGHZ (R9)
        cyc(4, 3'd4, 1'b1, 8'h00, 8'h00);
        cyc(0, 3'd4, 1'b1, 8'h00, 8'h00);
        cyc(2, 3'd3, 1'b1, 8'h00, 8'h3C);
        cyc(3, 3'd7, 1'b1, 8'h00, 8'h3C);
        // TLR clears (R1)
        cyc(1, 3'd0, 1'b1, 8'hFF, 8'hFF);
        cyc(0, 3'd0, 1'b1, 8'hFF, 8'hFF);

        // random run: instruction changes mixed with every strobe
        code = 3'd1;
        for (int k = 0; k < 4000; k++) begin
            int r = $urandom_range(0, 99);
            int s = (r < 2) ? 1 : (r < 20) ? 2 : (r < 65) ? 3 : (r < 82) ? 4 : 0;
            if ($urandom_range(0, 7) == 0) code = 3'($urandom_range(0, 7));
            cyc(s, code, 1'($urandom_range(0, 1)),
                N'($urandom), N'($urandom));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule